// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block orders the entry into and exit from a low-power state of a clock generator. An active-low request, which may change at any time with no relation to the block clock, is first brought through a synchronizer. Once the request is seen, the gates of the processor-locked output groups (processor, 66 MHz, bus, memory and interrupt-controller clocks) are closed together on the next falling edge of the internal processor clock. The gates of the free-running reference and 48 MHz clocks then close one by one, each during its own low phase. Only when every gate is closed are the crystal-oscillator stop and VCO stop controls raised.

On release, the oscillator and VCO are restarted at once. A timer then counts a programmable number of reference-clock periods to let the oscillator and PLL settle. After that, the locked group gates reopen on a processor-clock falling edge and the free-running gates reopen on their own low phase. A release that arrives while shutdown is still under way does not cut the sequence short: the block first reaches the fully stopped state and then wakes.

The block runs on one fast control clock. The processor-clock falling edge arrives as a one-cycle strobe `cpu_fall`. The free-running clock phases arrive as levels `free_lvl`, and reference periods arrive as one-cycle strobes `ref_tick`, all in the control clock domain.

Top module: `pd_seq_ctrl`

## Requirements
- R1: After synchronous reset all gate enables (`sync_en`, `free_en`) are 1 and `osc_stop`, `vco_stop` are 0.
- R2: With `pd_n` low, the gates in `sync_en` stay open until a `cpu_fall` strobe arrives. All bits of `sync_en` drop together in the cycle after the first `cpu_fall` strobe that is sampled once the synchronized request is seen. The synchronizer is 2 stages by default, and the state change takes one more register.
- R3: Each bit of `free_en` (bit 0 REF, bit 1 48 MHz) closes only in the cycle after its `free_lvl` bit is sampled 0 while shutting down. While its level stays 1 it stays open, and each bit behaves independently of the other.
- R4: `osc_stop` and `vco_stop` rise together one cycle after the last gate closes. Neither is ever 1 while any bit of `sync_en` or `free_en` is 1.
- R5: If `pd_n` returns high during shutdown, before the stop controls rise, the sequence still completes to `osc_stop`=1 before waking.
- R6: When the synchronized request is released in the stopped state, `osc_stop` and `vco_stop` drop one cycle later. All gates stay closed until `wake_len` `ref_tick` strobes have been counted in the wake state.
- R7: When the count is complete, `sync_en` returns to all ones in the cycle after the next `cpu_fall`. Each `free_en` bit reopens one cycle after that, provided its level is 0.
- R8: With `wake_len` = 0 the gates in `sync_en` reopen on the first `cpu_fall` after the stop controls drop, with no `ref_tick` needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_fall | input | 1 | One-cycle strobe at each internal processor-clock falling edge |
| free_lvl | input | NUM_FREE | Current level of each free-running clock (bit 0 REF, bit 1 48 MHz) |
| ref_tick | input | 1 | One-cycle strobe per reference-clock period |
| wake_len | input | CNT_W | Reference periods to wait before reopening gates |
| sync_en | output | NUM_SYNC | Gate enables of the processor-locked output groups |
| free_en | output | NUM_FREE | Gate enables of the free-running clocks |
| osc_stop | output | 1 | Stop the crystal oscillator |
| vco_stop | output | 1 | Stop the PLL VCO |

## Verification
The bench holds the request low with no processor-edge strobe and checks that the locked gates stay open; a design that closed them on the request itself would cut a clock pulse short. It keeps the free-running levels high so that a gate closing without waiting for a low phase is caught. It then lowers the two levels at different times and checks that the stop controls rise only after the later one. It also releases the request mid-shutdown, which catches a design that aborts straight back to running. Finally it strobes the processor edge before the settle count ends and again with a zero count, which catches an off-by-one timer or a wake that ignores the count.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_STOP_SYNC  = 3'd1,
    ST_STOP_ASYNC = 3'd2,
    ST_OSC_OFF    = 3'd3,
    ST_WAKE       = 3'd4
  } pd_state_t;
endpackage

// File: rtl/pd_req_sync.sv
module pd_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic req
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], async_n};
  end

  assign req = ~chain_q[STAGES-1];
endmodule

// File: rtl/free_clk_gate.sv
module free_clk_gate (
  input  logic clk,
  input  logic rst,
  input  logic park_req,
  input  logic lvl,
  output logic en,
  output logic parked
);
  logic en_q;

  // Enable only changes while the gated clock is low, so no pulse is cut.
  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b1;
    else if (!lvl) en_q <= ~park_req;
  end

  assign en     = en_q;
  assign parked = ~en_q;

  AST_PARK_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> $past(!lvl && park_req)); // R3
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt_q <= '0;
    else if (tick && !done) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> (cnt_q == '0)); // R6
endmodule

// File: rtl/pd_seq_ctrl.sv
module pd_seq_ctrl
  import pd_seq_pkg::*;
#(
  parameter int NUM_SYNC    = 5,
  parameter int NUM_FREE    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pd_n,
  input  logic                cpu_fall,
  input  logic [NUM_FREE-1:0] free_lvl,
  input  logic                ref_tick,
  input  logic [CNT_W-1:0]    wake_len,
  output logic [NUM_SYNC-1:0] sync_en,
  output logic [NUM_FREE-1:0] free_en,
  output logic                osc_stop,
  output logic                vco_stop
);
  localparam logic [NUM_SYNC-1:0] SYNC_ALL = {NUM_SYNC{1'b1}};

  pd_state_t           state_q;
  logic                pd_req;
  logic                wake_done;
  logic                park_req;
  logic [NUM_FREE-1:0] free_parked;
  logic [NUM_SYNC-1:0] sync_en_q;
  logic                osc_q;
  logic                vco_q;

  pd_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_n(pd_n), .req(pd_req)
  );

  assign park_req = (state_q != ST_RUN);

  for (genvar g = 0; g < NUM_FREE; g++) begin : g_free
    free_clk_gate u_gate (
      .clk(clk), .rst(rst), .park_req(park_req),
      .lvl(free_lvl[g]), .en(free_en[g]), .parked(free_parked[g])
    );
  end

  wake_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .run(state_q == ST_WAKE),
    .tick(ref_tick), .limit(wake_len), .done(wake_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      sync_en_q <= SYNC_ALL;
      osc_q     <= 1'b0;
      vco_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: if (pd_req) state_q <= ST_STOP_SYNC;
        ST_STOP_SYNC: if (cpu_fall) begin
          sync_en_q <= '0;
          state_q   <= ST_STOP_ASYNC;
        end
        ST_STOP_ASYNC: if (&free_parked) begin
          osc_q   <= 1'b1;
          vco_q   <= 1'b1;
          state_q <= ST_OSC_OFF;
        end
        ST_OSC_OFF: if (!pd_req) begin
          osc_q   <= 1'b0;
          vco_q   <= 1'b0;
          state_q <= ST_WAKE;
        end
        ST_WAKE: if (wake_done && cpu_fall) begin
          sync_en_q <= SYNC_ALL;
          state_q   <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign sync_en  = sync_en_q;
  assign osc_stop = osc_q;
  assign vco_stop = vco_q;

  AST_OSC_ONLY_WHEN_PARKED: assert property (@(posedge clk) disable iff (rst)
    osc_q |-> (sync_en_q == '0 && free_en == '0)); // R4
  AST_STOPS_PAIRED: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_q) |-> $rose(vco_q)); // R4
  AST_SYNC_CLOSE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_en_q[0]) |-> $past(cpu_fall)); // R2
  AST_SYNC_OPEN_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_en_q[0]) |-> $past(cpu_fall && wake_done)); // R7
  AST_NO_ABORT_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP_ASYNC) |=> (state_q == ST_STOP_ASYNC || state_q == ST_OSC_OFF)); // R5
endmodule

// File: tb/pd_seq_ctrl_tb_top.sv
module pd_seq_ctrl_tb_top;
  localparam int NS = 5;
  localparam int NF = 2;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_n = 1'b1;
  logic cpu_fall = 1'b0;
  logic [NF-1:0] free_lvl = '1;
  logic ref_tick = 1'b0;
  logic [CW-1:0] wake_len = 16'd3;
  logic [NS-1:0] sync_en;
  logic [NF-1:0] free_en;
  logic osc_stop, vco_stop;

  int n_chk = 0;
  int n_bad = 0;
  int order_bad = 0;

  always #2 clk = ~clk;

  pd_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .pd_n(pd_n), .cpu_fall(cpu_fall),
    .free_lvl(free_lvl), .ref_tick(ref_tick), .wake_len(wake_len),
    .sync_en(sync_en), .free_en(free_en), .osc_stop(osc_stop), .vco_stop(vco_stop)
  );

  // Advance one edge; inputs change and outputs are sampled 1 ns after it.
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && (osc_stop || vco_stop) && (sync_en != '0 || free_en != '0)) order_bad++;
  end

  task automatic pulse_fall();
    cpu_fall = 1'b1; step(); cpu_fall = 1'b0;
  endtask

  task automatic pulse_tick();
    ref_tick = 1'b1; step(); ref_tick = 1'b0; step();
  endtask

  task automatic t_reset();
    chk("R1 sync_en", sync_en, {NS{1'b1}});
    chk("R1 free_en", free_en, {NF{1'b1}});
    chk("R1 stops", {osc_stop, vco_stop}, 0);
  endtask

  task automatic t_full_cycle();
    free_lvl = 2'b11; wake_len = 16'd3;
    pd_n = 1'b0;
    step(6);
    chk("R2 open before edge", sync_en, {NS{1'b1}});
    pulse_fall();
    chk("R2 closed after edge", sync_en, 0);
    step(2);
    chk("R3 free held high stays open", free_en, 2'b11);
    chk("R4 no stop while open", osc_stop, 0);
    free_lvl[1] = 1'b0; step();
    chk("R3 48MHz gate closes", free_en, 2'b01);
    step();
    chk("R4 still running", osc_stop, 0);
    free_lvl[0] = 1'b0; step();
    chk("R3 REF gate closes", free_en, 2'b00);
    chk("R4 not yet stopped", osc_stop, 0);
    step();
    chk("R4 stops rise together", {osc_stop, vco_stop}, 2'b11);
    pd_n = 1'b1; step(2);
    chk("R6 stop held during sync", osc_stop, 1);
    step();
    chk("R6 stops drop", {osc_stop, vco_stop}, 2'b00);
    pulse_tick(); pulse_tick();
    pulse_fall(); step();
    chk("R6 gates closed before count", {sync_en, free_en}, 0);
    pulse_tick();
    pulse_fall();
    chk("R7 sync reopen", sync_en, {NS{1'b1}});
    chk("R7 free not yet", free_en, 2'b00);
    step();
    chk("R7 free reopen", free_en, 2'b11);
  endtask

  task automatic t_early_release();
    bit seen_stop = 0;
    free_lvl = 2'b00; wake_len = 16'd1;
    pd_n = 1'b0; step(4);
    pd_n = 1'b1; step(3);
    chk("R5 still open awaiting edge", sync_en, {NS{1'b1}});
    pulse_fall();
    for (int i = 0; i < 10; i++) begin
      if (osc_stop) seen_stop = 1;
      step();
    end
    chk("R5 reached stop", seen_stop, 1);
    chk("R5 then woke", osc_stop, 0);
    pulse_tick(); pulse_fall();
    chk("R5 back to run", sync_en, {NS{1'b1}});
    step();
  endtask

  task automatic t_zero_wait();
    free_lvl = 2'b00; wake_len = 16'd0;
    pd_n = 1'b0; step(4);
    pulse_fall(); step(3);
    chk("R8 stopped", osc_stop, 1);
    pd_n = 1'b1; step(3);
    chk("R8 stop dropped", osc_stop, 0);
    pulse_fall();
    chk("R8 reopen without ticks", sync_en, {NS{1'b1}});
    step();
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step();
    t_reset();
    t_full_cycle();
    t_early_release();
    t_zero_wait();
    chk("R4 order monitor", order_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule